// File: doc/BRIEF.md
# Power-Good Window Monitor with Qualification Delay

This block watches a digitized supply-voltage code and raises a single power-good flag once that code has stayed inside a tolerance band around a target code for a programmable number of clock ticks, with no fault reported during that time. The band is asymmetric. Its ceiling and its floor are each set by their own percentage register. In a typical setup the ceiling is 15 percent above target, the floor is 10 percent below target, and the delay is 1 ms of clock ticks. With those settings the flag can replace a separate reset supervisor for the logic that the supply feeds.

The measured code, the target code, the fault indication and the three register values all arrive as plain input ports. The block contains no converter, no register interface and no fault logic. Any change on these inputs is evaluated on the next clock edge. If the change breaks the band or signals a fault, the flag drops on that edge. The qualification count then starts again from zero.

Top module: `pg_monitor`

## Requirements
- R1: While the reset input is low the flag is low and the qualification count is cleared. After reset is released the flag stays low until the qualification has been completed again.
- R2: The ceiling is floor(target × (100 + up_pct) / 100) and it is inclusive. A code equal to the ceiling counts as in band. A code one above the ceiling counts as out of band.
- R3: The floor is floor(target × (100 − dn_pct) / 100) and it is inclusive. A dn_pct above 100 is treated as 100, which gives a floor of zero.
- R4: A clock edge that samples the fault input high leaves the flag low after that edge.
- R5: With delay register value D held constant, the flag rises on the (D+1)-th consecutive clock edge at which band and fault conditions all hold.
- R6: With D = 0 the flag rises on the first clock edge at which the conditions hold.
- R7: The flag falls on the first edge that samples a failed condition. The count restarts from zero, so a full D+1 qualifying edges are needed again.
- R8: Changes to the target, the percentages or the delay take effect on the next edge. Lowering the delay to or below the edges already counted raises the flag on that next edge.
- R9: Once the flag is high it stays high while the conditions hold, even if the delay register is raised.
- R10: With up_pct = 15, dn_pct = 10 and a delay of 50000 ticks (1 ms at 50 MHz), the flag rises exactly 50001 qualifying edges after the conditions are met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| volt_i | input | CODE_W | Measured voltage code |
| target_i | input | CODE_W | Target voltage code |
| fault_i | input | 1 | High while any fault is reported |
| up_pct_i | input | PCT_W | Ceiling margin in whole percent |
| dn_pct_i | input | PCT_W | Floor margin in whole percent |
| delay_i | input | DLY_W | Qualification delay in clock ticks |
| pg_o | output | 1 | Power-good flag |

## Verification
The bench builds the block with a 10-bit code, 8-bit percentages and a 17-bit delay. The 8-bit percentages make it possible to drive a floor margin above 100 and check the clamp to zero. The 17-bit delay holds the full 1 ms count at 50 MHz, so the default timing can be run end to end. Short delays between 0 and 6 ticks, together with random codes placed around both limits, exercise the drop on a failed condition and the restart of the count many times in a few thousand cycles.

// File: rtl/pg_pkg.sv
package pg_pkg;

  parameter int unsigned PCT_FULL = 100;

  typedef enum logic [1:0] {
    PG_OFF  = 2'b00,
    PG_QUAL = 2'b01,
    PG_ON   = 2'b10
  } pg_state_e;

endpackage

// File: rtl/pg_limit_calc.sv
module pg_limit_calc #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned PCT_W  = 8,
  parameter bit          RAISE  = 1'b1,
  localparam int unsigned FAC_W = PCT_W + 2,
  localparam int unsigned LIM_W = CODE_W + FAC_W
) (
  input  logic [CODE_W-1:0] target_i,
  input  logic [PCT_W-1:0]  pct_i,
  output logic [LIM_W-1:0]  limit_o
);
  import pg_pkg::*;

  logic [FAC_W-1:0] factor;
  logic [LIM_W-1:0] product;

  generate
    if (RAISE) begin : g_ceiling
      always_comb factor = FAC_W'(PCT_FULL) + FAC_W'(pct_i);
    end else begin : g_floor
      always_comb begin
        if (FAC_W'(pct_i) > FAC_W'(PCT_FULL)) factor = '0;
        else                                   factor = FAC_W'(PCT_FULL) - FAC_W'(pct_i);
      end
    end
  endgenerate

  always_comb begin
    product = LIM_W'(target_i) * LIM_W'(factor);
    limit_o = product / LIM_W'(PCT_FULL);
  end

endmodule

// File: rtl/pg_window_cmp.sv
module pg_window_cmp #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned LIM_W  = 22
) (
  input  logic [CODE_W-1:0] volt_i,
  input  logic [LIM_W-1:0]  hi_lim_i,
  input  logic [LIM_W-1:0]  lo_lim_i,
  input  logic              fault_i,
  output logic              ok_o
);
  logic [LIM_W-1:0] volt_ext;
  logic             under_ceiling;
  logic             over_floor;

  always_comb begin
    volt_ext      = LIM_W'(volt_i);
    under_ceiling = (volt_ext <= hi_lim_i);
    over_floor    = (volt_ext >= lo_lim_i);
    ok_o          = under_ceiling && over_floor && !fault_i;
  end

endmodule

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
  parameter int unsigned DLY_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ok_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             pg_o
);
  import pg_pkg::*;

  pg_state_e        state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             state_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    state_en = 1'b0;
    if (!ok_i) begin
      state_d  = PG_OFF;
      cnt_d    = '0;
      cnt_en   = (cnt_q != '0);
      state_en = (state_q != PG_OFF);
    end else begin
      case (state_q)
        PG_ON: begin
          state_d = PG_ON;
        end
        default: begin
          if (cnt_q >= delay_i) begin
            state_d  = PG_ON;
            state_en = 1'b1;
          end else begin
            state_d  = PG_QUAL;
            cnt_d    = cnt_q + 1'b1;
            cnt_en   = 1'b1;
            state_en = (state_q != PG_QUAL);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PG_OFF;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pg_o = (state_q == PG_ON);

endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned PCT_W  = 8,
  parameter int unsigned DLY_W  = 17,
  localparam int unsigned LIM_W = CODE_W + PCT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] volt_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic              fault_i,
  input  logic [PCT_W-1:0]  up_pct_i,
  input  logic [PCT_W-1:0]  dn_pct_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic              pg_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [LIM_W-1:0] hi_lim;
  logic [LIM_W-1:0] lo_lim;
  logic             cond_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  pg_limit_calc #(.CODE_W(CODE_W), .PCT_W(PCT_W), .RAISE(1'b1)) u_hi (
    .target_i (target_i),
    .pct_i    (up_pct_i),
    .limit_o  (hi_lim)
  );

  pg_limit_calc #(.CODE_W(CODE_W), .PCT_W(PCT_W), .RAISE(1'b0)) u_lo (
    .target_i (target_i),
    .pct_i    (dn_pct_i),
    .limit_o  (lo_lim)
  );

  pg_window_cmp #(.CODE_W(CODE_W), .LIM_W(LIM_W)) u_cmp (
    .volt_i   (volt_i),
    .hi_lim_i (hi_lim),
    .lo_lim_i (lo_lim),
    .fault_i  (fault_i),
    .ok_o     (cond_ok)
  );

  pg_qual_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .ok_i    (cond_ok),
    .delay_i (delay_i),
    .pg_o    (pg_o)
  );

endmodule

// File: rtl/pg_monitor_chk.sv
module pg_monitor_chk #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned LIM_W  = 22
) (
  input logic              clk_i,
  input logic              rst_async_ni,
  input logic              rst_ni,
  input logic              pg_o,
  input logic              cond_ok,
  input logic              fault_i,
  input logic [CODE_W-1:0] volt_i,
  input logic [LIM_W-1:0]  hi_lim,
  input logic [LIM_W-1:0]  lo_lim
);

  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_async_ni |-> !pg_o);

  // R4
  fault_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !pg_o);

  // R7
  drop_on_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_ok |=> !pg_o);

  // R5
  rise_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_o) |-> $past(cond_ok));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_o && cond_ok) |=> pg_o);

  // R2
  ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_o |-> $past(LIM_W'(volt_i) <= hi_lim));

  // R3
  floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_o |-> $past(LIM_W'(volt_i) >= lo_lim));

endmodule

bind pg_monitor pg_monitor_chk #(.CODE_W(CODE_W), .LIM_W(LIM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_async_ni (rst_ni),
  .rst_ni       (rst_sync_n),
  .pg_o         (pg_o),
  .cond_ok      (cond_ok),
  .fault_i      (fault_i),
  .volt_i       (volt_i),
  .hi_lim       (hi_lim),
  .lo_lim       (lo_lim)
);

// File: tb/sim_pg_monitor.sv
`timescale 1ns/1ps
module sim_pg_monitor;
  localparam int CODE_W = 10;
  localparam int PCT_W  = 8;
  localparam int DLY_W  = 17;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CODE_W-1:0] volt, target;
  logic              fault;
  logic [PCT_W-1:0]  up_pct, dn_pct;
  logic [DLY_W-1:0]  delay;
  logic              pg;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int run;
  bit exp_pg;

  always #10 clk = ~clk;

  pg_monitor #(.CODE_W(CODE_W), .PCT_W(PCT_W), .DLY_W(DLY_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .volt_i(volt), .target_i(target),
    .fault_i(fault), .up_pct_i(up_pct), .dn_pct_i(dn_pct),
    .delay_i(delay), .pg_o(pg)
  );

  function automatic bit cond_now();
    int t, hi, lo, dn;
    t  = int'(target);
    dn = (int'(dn_pct) > 100) ? 100 : int'(dn_pct);
    hi = (t * (100 + int'(up_pct))) / 100;
    lo = (t * (100 - dn)) / 100;
    return !fault && int'(volt) <= hi && int'(volt) >= lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run = 0;
      exp_pg = 1'b0;
    end else if (!cond_now()) begin
      run = 0;
      exp_pg = 1'b0;
    end else begin
      if (!exp_pg && run >= int'(delay)) exp_pg = 1'b1;
      run = run + 1;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (pg !== exp_pg) begin
        errors++;
        $display("FAIL %s t=%0t pg actual=%0b expected=%0b", tag, $time, pg, exp_pg);
      end
    end
  endtask

  task automatic expect_pg(input string r, input bit v);
    checks++;
    if (pg !== v) begin
      errors++;
      $display("FAIL %s t=%0t pg actual=%0b expected=%0b", r, $time, pg, v);
    end
  endtask

  initial begin
    #(150000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; volt = '0; target = '0; fault = 1'b1;
    up_pct = 8'd15; dn_pct = 8'd10; delay = 17'd5;
    // R1 reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    expect_pg("R1", 1'b0);
    rst_n = 1'b1;
    cyc(4);
    target = 10'd500; volt = 10'd500; fault = 1'b0;
    // R5: D=5 -> rises on 6th qualifying edge
    tag = "R5";
    cyc(5); expect_pg("R5", 1'b0);
    cyc(1); expect_pg("R5", 1'b1);
    // R2 ceiling 575 inclusive
    tag = "R2";
    volt = 10'd575; cyc(2); expect_pg("R2", 1'b1);
    volt = 10'd576; cyc(1); expect_pg("R2", 1'b0);
    // R3 floor 450 inclusive
    tag = "R3";
    volt = 10'd450; cyc(6); expect_pg("R3", 1'b1);
    volt = 10'd449; cyc(1); expect_pg("R3", 1'b0);
    dn_pct = 8'd120; volt = 10'd0; cyc(8); expect_pg("R3", 1'b1);
    dn_pct = 8'd10; volt = 10'd500; cyc(2);
    // R4 fault pulse
    tag = "R4";
    cyc(6); expect_pg("R4", 1'b1);
    fault = 1'b1; cyc(1); expect_pg("R4", 1'b0);
    fault = 1'b0;
    // R7 restart from zero
    tag = "R7";
    cyc(3); volt = 10'd600; cyc(1); volt = 10'd500;
    cyc(5); expect_pg("R7", 1'b0);
    cyc(1); expect_pg("R7", 1'b1);
    // R6 zero delay
    tag = "R6";
    fault = 1'b1; cyc(1); fault = 1'b0; delay = '0;
    cyc(1); expect_pg("R6", 1'b1);
    // R8 delay lowered mid-count, then target moved
    tag = "R8";
    fault = 1'b1; cyc(1); fault = 1'b0; delay = 17'd40;
    cyc(10); expect_pg("R8", 1'b0);
    delay = 17'd3; cyc(1); expect_pg("R8", 1'b1);
    target = 10'd300; cyc(1); expect_pg("R8", 1'b0);
    up_pct = 8'd70; cyc(4); expect_pg("R8", 1'b1);
    up_pct = 8'd15; target = 10'd500;
    // R9 raising delay while high keeps flag
    tag = "R9";
    cyc(4); expect_pg("R9", 1'b1);
    delay = 17'd100; cyc(3); expect_pg("R9", 1'b1);
    // R7 random sweep near both limits
    tag = "R7";
    for (int k = 0; k < 3000; k++) begin
      volt  = 10'($urandom_range(440, 585));
      fault = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 30) == 0) delay = 17'($urandom_range(0, 6));
      if ($urandom_range(0, 3) != 0) volt = 10'($urandom_range(455, 570));
      cyc(1);
    end
    // R10 default window and 1 ms delay
    tag = "R10";
    fault = 1'b1; cyc(1);
    fault = 1'b0; volt = 10'd500; up_pct = 8'd15; dn_pct = 8'd10; delay = 17'd50000;
    cyc(50000); expect_pg("R10", 1'b0);
    cyc(1); expect_pg("R10", 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule